// File: doc/BRIEF.md
# Debug Vector Serial Probe

This block lets a wide internal status vector be watched on an ordinary oscilloscope through only two spare pins. A divider built from the system clock marks out fixed-length time slots. A 5-bit slot counter walks through a 32-slot frame and places one bit of the vector on a serial data pin in each slot. A second pin goes high only in the first slot of each frame, so the scope can trigger on it.

The vector is copied into a shadow register at the moment a frame begins. Every frame therefore shows one coherent sample, even if the live vector changes while the frame is being sent. The block has two modes. In continuous mode, frames follow one another with no space between them. In triggered mode, a frame is sent only when a start request arrives. Tying that request to a "vector updated" strobe inside the chip gives one frame per change.

Top module: `dbg_serial_probe`

## Requirements
- R1: While reset is high, and afterwards until the first frame starts, both the data pin and the marker pin are low.
- R2: Every slot lasts exactly CLKS_PER_SLOT system clocks. The first slot boundary falls CLKS_PER_SLOT clocks after reset is released, and the next ones follow at that same spacing. A frame is 32 consecutive slots, numbered 0 to 31.
- R3: The marker pin is high for the whole of slot 0 of a frame and low in every other slot and while idle.
- R4: In slot k, for k from 0 to 29, the data pin carries bit k of the captured vector, so bit 0 goes first. In slots 30 and 31 the data pin is low.
- R5: The vector is captured at the slot boundary where a frame begins. Changes to the live vector during a frame do not appear until a later frame.
- R6: In continuous mode (free_run high), a frame starts at the next slot boundary and further frames follow with no idle slot between them. When free_run is cleared, the frame in progress finishes all 32 slots and then the pins stay idle.
- R7: In triggered mode (free_run low), a start request that arrives while idle starts a frame at the next slot boundary.
- R8: In triggered mode, a start request that arrives during a frame is held. The next frame then begins in the slot right after slot 31. Several requests during one frame produce only one extra frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| free_run | input | 1 | 1 = continuous frames, 0 = one frame per start request |
| start_req | input | 1 | Requests one frame in triggered mode |
| watch_vec | input | VEC_W (30) | Live vector to be observed |
| probe_data | output | 1 | Serial data pin, one vector bit per slot |
| probe_mark | output | 1 | Frame marker pin, high during slot 0 |

## Verification
The bench changes the live vector in the middle of a frame. A design that sampled the vector bit by bit would then show a mixed frame, where the later bits carry the new value. Frames use asymmetric patterns, so a design that sent the most significant bit first would give a data mismatch in almost every slot. An all-ones frame checks that slots 30 and 31 are forced low, which catches a design that leaks vector bits or stale data into the gap. In triggered mode the bench sends two requests during one frame and then clears continuous mode part-way through a frame. A design that dropped held requests would idle where a frame is expected. One that counted each request would send a surplus frame. One that cut the frame off on the mode change would end the frame early.

// File: rtl/dbg_probe_pkg.sv
package dbg_probe_pkg;

    typedef enum logic {
        RUN_TRIGGERED = 1'b0,
        RUN_FREE      = 1'b1
    } run_mode_t;

    typedef struct packed {
        logic active;   // a frame is being sent
        logic pending;  // a start request waits for the next boundary
    } seq_flags_t;

    // A new frame is wanted when running freely, when a request is held,
    // or when a request arrives in the boundary cycle itself.
    function automatic logic start_wanted(run_mode_t mode, logic held, logic req);
        return (mode == RUN_FREE) || held || req;
    endfunction

endpackage

// File: rtl/probe_tick_gen.sv
module probe_tick_gen #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/probe_frame_ctrl.sv
module probe_frame_ctrl
    import dbg_probe_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  run_mode_t         mode,
    input  logic              start_req,
    output logic              active,
    output logic [SLOT_W-1:0] slot,
    output logic              load
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

    seq_flags_t        flags_q;
    logic [SLOT_W-1:0] slot_q;
    logic              at_boundary;

    // A frame may begin only when idle or at the end of the final slot.
    assign at_boundary = !flags_q.active || (slot_q == LAST_SLOT);
    assign load        = tick && at_boundary &&
                         start_wanted(mode, flags_q.pending, start_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            slot_q  <= '0;
        end else begin
            if (load) begin
                flags_q.active <= 1'b1;
                slot_q         <= '0;
            end else if (tick && flags_q.active) begin
                if (slot_q == LAST_SLOT) begin
                    flags_q.active <= 1'b0;
                    slot_q         <= '0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end

            if (load) begin
                flags_q.pending <= 1'b0;
            end else if (start_req && (mode == RUN_TRIGGERED)) begin
                flags_q.pending <= 1'b1;
            end
        end
    end

    assign active = flags_q.active;
    assign slot   = slot_q;
endmodule

// File: rtl/probe_shift_out.sv
module probe_shift_out #(
    parameter int VEC_W  = 30,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [VEC_W-1:0]  watch_vec,
    input  logic              active,
    input  logic [SLOT_W-1:0] slot,
    output logic [VEC_W-1:0]  snap,
    output logic              probe_data,
    output logic              probe_mark
);
    localparam int FRAME_SLOTS = 1 << SLOT_W;

    logic [VEC_W-1:0]       snap_q;
    logic [FRAME_SLOTS-1:0] slot_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (load) begin
            snap_q <= watch_vec;
        end
    end

    // Slots past the vector width read zero and form the idle gap.
    generate
        if (VEC_W < FRAME_SLOTS) begin : g_gap
            assign slot_bits = {{(FRAME_SLOTS - VEC_W){1'b0}}, snap_q};
        end else begin : g_full
            assign slot_bits = snap_q[FRAME_SLOTS-1:0];
        end
    endgenerate

    assign probe_data = active && slot_bits[slot];
    assign probe_mark = active && (slot == '0);
    assign snap       = snap_q;
endmodule

// File: rtl/dbg_serial_probe.sv
module dbg_serial_probe
    import dbg_probe_pkg::*;
#(
    parameter int VEC_W         = 30,
    parameter int SLOT_W        = 5,
    parameter int CLKS_PER_SLOT = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             free_run,
    input  logic             start_req,
    input  logic [VEC_W-1:0] watch_vec,
    output logic             probe_data,
    output logic             probe_mark
);
    logic              tick;
    logic              active;
    logic              load;
    logic [SLOT_W-1:0] slot;
    logic [VEC_W-1:0]  snap;
    run_mode_t         mode;

    assign mode = free_run ? RUN_FREE : RUN_TRIGGERED;

    probe_tick_gen #(
        .DIV (CLKS_PER_SLOT)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    probe_frame_ctrl #(
        .SLOT_W (SLOT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (mode),
        .start_req (start_req),
        .active    (active),
        .slot      (slot),
        .load      (load)
    );

    probe_shift_out #(
        .VEC_W  (VEC_W),
        .SLOT_W (SLOT_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .watch_vec  (watch_vec),
        .active     (active),
        .slot       (slot),
        .snap       (snap),
        .probe_data (probe_data),
        .probe_mark (probe_mark)
    );
endmodule

// File: rtl/dbg_serial_probe_chk.sv
module dbg_serial_probe_chk #(
    parameter int VEC_W  = 30,
    parameter int SLOT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              load,
    input logic              active,
    input logic [SLOT_W-1:0] slot,
    input logic [VEC_W-1:0]  snap,
    input logic              probe_data,
    input logic              probe_mark
);
    // R2: the slot index steps by one at each boundary inside a frame
    a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
        (tick && active && !load && (slot != '1)) |=> (slot == $past(slot) + 1'b1));

    // R2: the slot index holds between boundaries
    a_r2_slot_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(slot));

    // R3: the marker is seen only in slot 0 of an active frame
    a_r3_mark_slot0: assert property (@(posedge clk) disable iff (rst)
        probe_mark |-> (active && (slot == '0)));

    // R4: slots beyond the vector width drive the data pin low
    a_r4_gap_low: assert property (@(posedge clk) disable iff (rst)
        (active && (32'(slot) >= VEC_W)) |-> !probe_data);

    // R5: the shadow copy changes only when a frame is loaded
    a_r5_snap_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(snap));

    // R7: a frame starts only on a slot boundary
    a_r7_start_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(tick));
endmodule

bind dbg_serial_probe dbg_serial_probe_chk #(
    .VEC_W  (VEC_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .load       (load),
    .active     (active),
    .slot       (slot),
    .snap       (snap),
    .probe_data (probe_data),
    .probe_mark (probe_mark)
);

// File: tb/tb_dbg_serial_probe.sv
module tb_dbg_serial_probe;
    localparam int VEC_W = 30;
    localparam int N     = 4;   // clocks per slot for this bench
    localparam int SLOTS = 32;

    typedef struct {
        logic  d;
        logic  m;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             free_run = 1'b0;
    logic             start_req = 1'b0;
    logic [VEC_W-1:0] watch_vec = '0;
    logic             probe_data;
    logic             probe_mark;

    int   ecount = 0;
    int   n_cmp  = 0;
    int   n_bad  = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    dbg_serial_probe #(
        .VEC_W         (VEC_W),
        .SLOT_W        (5),
        .CLKS_PER_SLOT (N)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .free_run   (free_run),
        .start_req  (start_req),
        .watch_vec  (watch_vec),
        .probe_data (probe_data),
        .probe_mark (probe_mark)
    );

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    task automatic push_idle(int n, string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{1'b0, 1'b0, tag});
    endtask

    task automatic push_frame(logic [VEC_W-1:0] v, string tag);
        for (int k = 0; k < SLOTS; k++)
            exp_q.push_back('{(k < VEC_W) ? v[k] : 1'b0, (k == 0), tag});
    endtask

    task automatic at_period(int p);
        do @(negedge clk); while (ecount != p * N + 1);
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    // Monitor: one comparison per slot period, taken mid-slot.
    always @(negedge clk) begin
        if (!rst && (ecount % N == 2)) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: output slot %0d with no expected item (actual d=%b m=%b, expected none)",
                         ecount / N, probe_data, probe_mark);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp += 2;
                if (probe_data !== e.d) begin
                    n_bad++;
                    $display("FAIL %s: period %0d data actual %b expected %b",
                             e.tag, ecount / N, probe_data, e.d);
                end
                if (probe_mark !== e.m) begin
                    n_bad++;
                    $display("FAIL R3 %s: period %0d mark actual %b expected %b",
                             e.tag, ecount / N, probe_mark, e.m);
                end
            end
        end
    end

    localparam logic [VEC_W-1:0] V1 = 30'h3FFF_FFFF;  // all ones: gap check
    localparam logic [VEC_W-1:0] V2 = 30'h1234_5678;
    localparam logic [VEC_W-1:0] V3 = 30'h2AAA_AAA9;
    localparam logic [VEC_W-1:0] V4 = 30'h0F0F_0F0E;

    initial begin : watchdog
        #(4 * 6000);
        n_cmp++; n_bad++;
        $display("FAIL R2: watchdog expired (actual hung, expected finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : driver
        // Scoreboard script, one item per slot period.
        push_idle(2, "R1 R7");         // periods 0..1
        push_frame(V1, "R4 R5 R7");    // 2..33 triggered, vector changes mid-frame
        push_frame(V2, "R4 R8");       // 34..65 held requests, only one frame
        push_idle(2, "R8");            // 66..67
        push_frame(V3, "R4 R6");       // 68..99 free running
        push_frame(V4, "R5 R6");       // 100..131 back to back
        push_idle(4, "R6");            // 132..135 stops after frame

        watch_vec = V1;
        repeat (3) @(negedge clk);
        n_cmp += 2;   // R1: pins low during reset
        if (probe_data !== 1'b0 || probe_mark !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: in reset d=%b m=%b expected 0 0", probe_data, probe_mark);
        end
        rst = 1'b0;

        at_period(1);  pulse_start();          // R7
        at_period(10); watch_vec = V2;         // R5
        at_period(15); pulse_start();          // R8
        at_period(20); pulse_start();          // R8 collapse
        at_period(67); free_run = 1'b1; watch_vec = V3;   // R6
        at_period(80); watch_vec = V4;
        at_period(110); free_run = 1'b0;
        at_period(136);

        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d expected items left, expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule